// File: doc/BRIEF.md
# ADC Conversion Sequencer with Priority Injection

This block controls a single analog-to-digital converter core and feeds it channel numbers from two queues. The routine queue (the "regular" group) is a programmed list of up to sixteen channels. Software starts it with a start pulse, or a timer starts it with a trigger pulse. Every regular result lands in one shared result register, and that register raises a DMA request for a DMA engine to collect. In continuous mode the list starts again from its first entry when it reaches the end.

The priority queue (the "injected" group) holds up to four channels and can also be started by software or by a trigger. It never cuts a conversion short. When it is triggered, it waits for the conversion in flight to finish, then converts all of its own channels before any further regular work. Each of its results goes into its own slot, and the end of the injected list raises a one-cycle interrupt pulse. The regular list then carries on from the first rank it had not yet converted.

The converter is modelled as a handshake: a start pulse with a channel number, a busy level, and a done pulse that carries the result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `cv_start_o`, `dma_req_o`, `reg_overrun_o`, `inj_irq_o`, `reg_active_o` and `inj_active_o` are low, and `reg_result_o` and all injected slots are zero.
- R2: `reg_count_i` holds the regular list length minus one, so the values 0 to 15 select 1 to 16 entries. A started regular list converts ranks 0 up to `reg_count_i` in order. Rank k takes its channel from bits [k*CH_W +: CH_W] of `reg_chan_list_i`.
- R3: Each regular result is written to `reg_result_o` and sets `dma_req_o`. `dma_req_o` stays high until a cycle in which `dma_ack_i` is high.
- R4: `cv_start_o` pulses for one cycle only when the converter is not busy and no earlier conversion is still waiting for its done pulse. Every start is followed by exactly one accepted done pulse before the next start.
- R5: `inj_count_i` holds the injected list length minus one, so the values 0 to 3 select 1 to 4 entries. Injected rank k takes its channel from bits [k*CH_W +: CH_W] of `inj_chan_list_i`. Its result goes to bits [k*RES_W +: RES_W] of `inj_results_o`, and the other slots keep their values.
- R6: `inj_irq_o` pulses high for exactly one cycle after the last injected result is stored, once per injected list.
- R7: An injected start that arrives during a regular conversion lets that conversion finish. All injected ranks are then converted before any further regular rank.
- R8: After an injected list ends, the regular list resumes at the rank after the last one converted. Injected results never appear on `reg_result_o` and never raise `dma_req_o`.
- R9: With `reg_loop_i` high, the regular list restarts at rank 0 after its last rank. With `reg_loop_i` low, it stops after its last rank.
- R10: A regular result that arrives while `dma_req_o` is still high and `dma_ack_i` is low sets `reg_overrun_o`. The flag stays set until reset.
- R11: A start pulse for a group, from software or from the trigger, is ignored while that group is already active. Either source starts an idle group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_chan_list_i | input | N_REG*CH_W | Regular channel for each rank |
| reg_count_i | input | $clog2(N_REG) | Regular list length minus one |
| reg_loop_i | input | 1 | Continuous mode for the regular list |
| reg_sw_go_i | input | 1 | Software start pulse, regular group |
| reg_hw_go_i | input | 1 | Trigger start pulse, regular group |
| inj_chan_list_i | input | N_INJ*CH_W | Injected channel for each rank |
| inj_count_i | input | $clog2(N_INJ) | Injected list length minus one |
| inj_sw_go_i | input | 1 | Software start pulse, injected group |
| inj_hw_go_i | input | 1 | Trigger start pulse, injected group |
| cv_start_o | output | 1 | Conversion start pulse to the converter |
| cv_chan_o | output | CH_W | Channel for the conversion being started |
| cv_busy_i | input | 1 | Converter is busy |
| cv_done_i | input | 1 | Conversion finished; result is valid |
| cv_result_i | input | RES_W | Conversion result |
| reg_result_o | output | RES_W | Shared regular result register |
| dma_req_o | output | 1 | DMA request for the regular result |
| dma_ack_i | input | 1 | DMA has taken the regular result |
| reg_overrun_o | output | 1 | Sticky regular overrun flag |
| inj_results_o | output | N_INJ*RES_W | Injected result slots, one per rank |
| inj_irq_o | output | 1 | End-of-injected-list interrupt pulse |
| reg_active_o | output | 1 | Regular list in progress |
| inj_active_o | output | 1 | Injected list in progress |

## Verification
The regular list is run with lengths 1, 4, 8 and 16, different channel strides, and both start sources. This separates rank-order mistakes, off-by-one length decoding and start-source mistakes. An injected start pulsed while a regular conversion is in flight checks three things: the in-flight conversion completes, the injected ranks come next, and the regular list picks up at the right rank rather than repeating or skipping one. Repeated start pulses during a run show whether a start for a busy group is ignored. A continuous two-entry list shows that the list wraps. Holding back the DMA acknowledge shows whether the overrun flag sets and stays set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic {GRP_REG = 1'b0, GRP_INJ = 1'b1} grp_e;
endpackage

// File: rtl/adc_rank_ctr.sv
module adc_rank_ctr #(
   parameter int DEPTH = 16,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          go_i,
   input  logic          adv_i,
   input  logic [IW-1:0] last_i,
   input  logic          wrap_i,
   output logic          run_o,
   output logic [IW-1:0] rank_o,
   output logic          end_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("adc_rank_ctr: DEPTH must be a power of two of at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_o  <= 1'b0;
         rank_o <= '0;
         end_o  <= 1'b0;
      end else begin
         end_o <= 1'b0;
         if (!run_o) begin
            rank_o <= '0;
            if (go_i) run_o <= 1'b1;
         end else if (adv_i) begin
            if (rank_o == last_i) begin
               rank_o <= '0;
               end_o  <= 1'b1;
               run_o  <= wrap_i;
            end else begin
               rank_o <= rank_o + 1'b1;
            end
         end
      end
   end

   a_r2_rank_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_o && adv_i && (rank_o != last_i) |=> rank_o == $past(rank_o) + 1'b1);
   a_r11_go_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_o && go_i && !adv_i |=> run_o && rank_o == $past(rank_o));
endmodule

// File: rtl/adc_inj_bank.sv
module adc_inj_bank #(
   parameter int N_SLOT = 4,
   parameter int RES_W  = 12,
   localparam int IW    = $clog2(N_SLOT)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wr_i,
   input  logic [IW-1:0]           idx_i,
   input  logic [RES_W-1:0]        data_i,
   output logic [N_SLOT*RES_W-1:0] bank_o
);
   for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) bank_o[s*RES_W +: RES_W] <= '0;
         else if (wr_i && idx_i == IW'(s)) bank_o[s*RES_W +: RES_W] <= data_i;
      end
   end

   a_r5_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(bank_o));
endmodule

// File: rtl/adc_reg_out.sv
module adc_reg_out #(
   parameter int RES_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [RES_W-1:0] data_i,
   input  logic             ack_i,
   output logic [RES_W-1:0] data_o,
   output logic             req_o,
   output logic             ovr_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_o <= '0;
         req_o  <= 1'b0;
         ovr_o  <= 1'b0;
      end else begin
         if (wr_i) begin
            data_o <= data_i;
            req_o  <= 1'b1;
            if (req_o && !ack_i) ovr_o <= 1'b1;
         end else if (ack_i) begin
            req_o <= 1'b0;
         end
      end
   end

   a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o && !ack_i |=> req_o);
   a_r10_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_o |=> ovr_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int N_REG = 16,
   parameter int N_INJ = 4,
   parameter int CH_W  = 5,
   parameter int RES_W = 12,
   localparam int REG_IW = $clog2(N_REG),
   localparam int INJ_IW = $clog2(N_INJ)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [N_REG*CH_W-1:0]  reg_chan_list_i,
   input  logic [REG_IW-1:0]      reg_count_i,
   input  logic                   reg_loop_i,
   input  logic                   reg_sw_go_i,
   input  logic                   reg_hw_go_i,
   input  logic [N_INJ*CH_W-1:0]  inj_chan_list_i,
   input  logic [INJ_IW-1:0]      inj_count_i,
   input  logic                   inj_sw_go_i,
   input  logic                   inj_hw_go_i,
   output logic                   cv_start_o,
   output logic [CH_W-1:0]        cv_chan_o,
   input  logic                   cv_busy_i,
   input  logic                   cv_done_i,
   input  logic [RES_W-1:0]       cv_result_i,
   output logic [RES_W-1:0]       reg_result_o,
   output logic                   dma_req_o,
   input  logic                   dma_ack_i,
   output logic                   reg_overrun_o,
   output logic [N_INJ*RES_W-1:0] inj_results_o,
   output logic                   inj_irq_o,
   output logic                   reg_active_o,
   output logic                   inj_active_o
);
   if (CH_W < 1 || RES_W < 1) begin : g_bad_width
      $error("adc_seq_ctrl: CH_W and RES_W must be positive");
   end

   logic              wait_q;
   grp_e              grp_q;
   logic [REG_IW-1:0] reg_rank;
   logic [INJ_IW-1:0] inj_rank;
   logic              reg_end;
   logic              reg_adv, inj_adv;
   logic [CH_W-1:0]   reg_ch, inj_ch;

   assign reg_adv = wait_q && cv_done_i && grp_q == GRP_REG;
   assign inj_adv = wait_q && cv_done_i && grp_q == GRP_INJ;
   assign reg_ch  = reg_chan_list_i[reg_rank*CH_W +: CH_W];
   assign inj_ch  = inj_chan_list_i[inj_rank*CH_W +: CH_W];

   adc_rank_ctr #(.DEPTH(N_REG)) u_reg_rank (
      .clk_i, .rst_ni,
      .go_i   (reg_sw_go_i | reg_hw_go_i),
      .adv_i  (reg_adv),
      .last_i (reg_count_i),
      .wrap_i (reg_loop_i),
      .run_o  (reg_active_o),
      .rank_o (reg_rank),
      .end_o  (reg_end)
   );

   adc_rank_ctr #(.DEPTH(N_INJ)) u_inj_rank (
      .clk_i, .rst_ni,
      .go_i   (inj_sw_go_i | inj_hw_go_i),
      .adv_i  (inj_adv),
      .last_i (inj_count_i),
      .wrap_i (1'b0),
      .run_o  (inj_active_o),
      .rank_o (inj_rank),
      .end_o  (inj_irq_o)
   );

   adc_reg_out #(.RES_W(RES_W)) u_reg_out (
      .clk_i, .rst_ni,
      .wr_i   (reg_adv),
      .data_i (cv_result_i),
      .ack_i  (dma_ack_i),
      .data_o (reg_result_o),
      .req_o  (dma_req_o),
      .ovr_o  (reg_overrun_o)
   );

   adc_inj_bank #(.N_SLOT(N_INJ), .RES_W(RES_W)) u_inj_bank (
      .clk_i, .rst_ni,
      .wr_i   (inj_adv),
      .idx_i  (inj_rank),
      .data_i (cv_result_i),
      .bank_o (inj_results_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wait_q     <= 1'b0;
         grp_q      <= GRP_REG;
         cv_start_o <= 1'b0;
         cv_chan_o  <= '0;
      end else begin
         cv_start_o <= 1'b0;
         if (wait_q && cv_done_i) wait_q <= 1'b0;
         if (!wait_q && !cv_busy_i) begin
            if (inj_active_o) begin
               cv_start_o <= 1'b1;
               cv_chan_o  <= inj_ch;
               grp_q      <= GRP_INJ;
               wait_q     <= 1'b1;
            end else if (reg_active_o) begin
               cv_start_o <= 1'b1;
               cv_chan_o  <= reg_ch;
               grp_q      <= GRP_REG;
               wait_q     <= 1'b1;
            end
         end
      end
   end

   a_r4_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cv_start_o |-> !$past(cv_busy_i));
   a_r4_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cv_start_o |=> !cv_start_o);
   a_r6_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inj_irq_o |=> !inj_irq_o);
   a_r7_inj_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cv_start_o && $past(inj_active_o) |-> grp_q == GRP_INJ);
   a_r8_no_inj_dma: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inj_adv && !dma_req_o |=> !dma_req_o);
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
   localparam int N_REG = 16, N_INJ = 4, CH_W = 5, RES_W = 12, LAT = 3;
   // table entry: {count-1[3:0], base channel[4:0], stride[4:0], use trigger}
   localparam logic [14:0] VEC [0:3] = '{
      {4'd0,  5'd3,  5'd1, 1'b0},
      {4'd3,  5'd10, 5'd2, 1'b1},
      {4'd7,  5'd31, 5'd3, 1'b0},
      {4'd15, 5'd0,  5'd5, 1'b1}};

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [N_REG*CH_W-1:0]  reg_list = '0;
   logic [3:0]             reg_cnt = '0;
   logic                   reg_loop = 1'b0, reg_sw = 1'b0, reg_hw = 1'b0;
   logic [N_INJ*CH_W-1:0]  inj_list = '0;
   logic [1:0]             inj_cnt = '0;
   logic                   inj_sw = 1'b0, inj_hw = 1'b0;
   logic                   cv_start, cv_busy = 1'b0, cv_done = 1'b0;
   logic [CH_W-1:0]        cv_chan;
   logic [RES_W-1:0]       cv_res = '0, reg_res;
   logic                   dma_req, dma_ack = 1'b0, ovr, irq, reg_act, inj_act;
   logic [N_INJ*RES_W-1:0] inj_res;

   adc_seq_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .reg_chan_list_i(reg_list), .reg_count_i(reg_cnt),
      .reg_loop_i(reg_loop), .reg_sw_go_i(reg_sw), .reg_hw_go_i(reg_hw),
      .inj_chan_list_i(inj_list), .inj_count_i(inj_cnt), .inj_sw_go_i(inj_sw),
      .inj_hw_go_i(inj_hw), .cv_start_o(cv_start), .cv_chan_o(cv_chan),
      .cv_busy_i(cv_busy), .cv_done_i(cv_done), .cv_result_i(cv_res),
      .reg_result_o(reg_res), .dma_req_o(dma_req), .dma_ack_i(dma_ack),
      .reg_overrun_o(ovr), .inj_results_o(inj_res), .inj_irq_o(irq),
      .reg_active_o(reg_act), .inj_active_o(inj_act));

   function automatic logic [RES_W-1:0] fres(input logic [CH_W-1:0] ch);
      return RES_W'((int'(ch) * 97 + 13) % 4096);
   endfunction

   // converter model and logs
   logic [CH_W-1:0]  ch_log  [0:255];
   logic [RES_W-1:0] res_log [0:255];
   int log_n = 0, res_n = 0, irq_n = 0, cnt = 0;
   logic [CH_W-1:0] ch_l = '0;
   logic auto_ack = 1'b1;

   always @(posedge clk) begin
      cv_done <= 1'b0;
      if (cv_start) begin
         cv_busy <= 1'b1; cnt <= LAT; ch_l <= cv_chan;
         ch_log[log_n % 256] <= cv_chan; log_n <= log_n + 1;
      end else if (cnt != 0) begin
         cnt <= cnt - 1;
         if (cnt == 1) begin cv_done <= 1'b1; cv_res <= fres(ch_l); cv_busy <= 1'b0; end
      end
      if (irq) irq_n <= irq_n + 1;
      if (dma_ack) dma_ack <= 1'b0;
      else if (dma_req && auto_ack) begin
         res_log[res_n % 256] <= reg_res; res_n <= res_n + 1; dma_ack <= 1'b1;
      end
   end

   int total = 0, bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (reg_act || inj_act) @(negedge clk);
      repeat (10) @(negedge clk);
   endtask

   task automatic set_reg(input int base, input int stride);
      for (int k = 0; k < N_REG; k++) reg_list[k*CH_W +: CH_W] = CH_W'((base + k*stride) % 32);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!cv_start && !dma_req && !ovr && !irq && !reg_act && !inj_act, "R1 outputs",
          {cv_start, dma_req, ovr, irq, reg_act, inj_act}, 0);
      chk(reg_res == 0 && inj_res == 0, "R1 results", reg_res, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: R2 order/length, R3 result + DMA, R11 both sources
      for (int v = 0; v < 4; v++) begin
         int l0, r0, n, ok_ch, ok_res;
         n = int'(VEC[v][14:11]) + 1;
         set_reg(int'(VEC[v][10:6]), int'(VEC[v][5:1]));
         reg_cnt = VEC[v][14:11];
         l0 = log_n; r0 = res_n;
         if (VEC[v][0]) pulse(reg_hw); else pulse(reg_sw);
         wait_idle();
         chk(log_n - l0 == n, "R2 conversion count", log_n - l0, n);
         ok_ch = 1; ok_res = 1;
         for (int k = 0; k < n; k++) begin
            if (ch_log[(l0+k)%256] != reg_list[k*CH_W +: CH_W]) ok_ch = 0;
            if (res_log[(r0+k)%256] != fres(reg_list[k*CH_W +: CH_W])) ok_res = 0;
         end
         chk(ok_ch == 1, "R2 rank order", ok_ch, 1);
         chk(ok_res == 1 && res_n - r0 == n, "R3 regular results via DMA", res_n - r0, n);
         chk(!dma_req && !ovr, "R3 request cleared after ack", {dma_req, ovr}, 0);
      end

      // injected alone, with a repeated start ignored: R5 R6 R11
      begin
         int l0, i0;
         for (int k = 0; k < N_INJ; k++) inj_list[k*CH_W +: CH_W] = CH_W'(4 + k);
         inj_cnt = 2'd3; l0 = log_n; i0 = irq_n;
         pulse(inj_sw);
         while (log_n < l0 + 2) @(negedge clk);
         pulse(inj_hw);
         wait_idle();
         chk(log_n - l0 == 4, "R11 injected restart ignored", log_n - l0, 4);
         chk(irq_n - i0 == 1, "R6 one interrupt per list", irq_n - i0, 1);
         for (int k = 0; k < N_INJ; k++)
            chk(inj_res[k*RES_W +: RES_W] == fres(CH_W'(4 + k)), "R5 injected slot",
                inj_res[k*RES_W +: RES_W], fres(CH_W'(4 + k)));
      end

      // preemption: R7 R8 R5
      begin
         int l0, r0, ok;
         logic [CH_W-1:0] exp [0:9];
         set_reg(20, 1); reg_cnt = 4'd7;
         inj_list[0 +: CH_W] = 5'd1; inj_list[CH_W +: CH_W] = 5'd2; inj_cnt = 2'd1;
         l0 = log_n; r0 = res_n;
         pulse(reg_sw);
         while (log_n < l0 + 3) @(negedge clk);
         pulse(inj_hw);
         wait_idle();
         exp = '{5'd20, 5'd21, 5'd22, 5'd1, 5'd2, 5'd23, 5'd24, 5'd25, 5'd26, 5'd27};
         ok = (log_n - l0 == 10);
         for (int k = 0; k < 10; k++) if (ch_log[(l0+k)%256] != exp[k]) ok = 0;
         chk(ok == 1, "R7 injected between conversions, R8 resume rank", ok, 1);
         ok = (res_n - r0 == 8);
         for (int k = 0; k < 8; k++) if (res_log[(r0+k)%256] != fres(CH_W'(20 + k))) ok = 0;
         chk(ok == 1, "R8 no injected result on DMA path", res_n - r0, 8);
         chk(inj_res[RES_W +: RES_W] == fres(5'd2) && inj_res[2*RES_W +: RES_W] == fres(5'd6),
             "R5 slot written, others kept", inj_res[RES_W +: RES_W], fres(5'd2));
      end

      // regular restart ignored: R11
      begin
         int l0;
         set_reg(12, 1); reg_cnt = 4'd2; l0 = log_n;
         pulse(reg_sw);
         while (log_n < l0 + 1) @(negedge clk);
         pulse(reg_hw);
         wait_idle();
         chk(log_n - l0 == 3, "R11 regular restart ignored", log_n - l0, 3);
      end

      // continuous mode: R9
      begin
         int l0, n, ok;
         set_reg(8, 1); reg_cnt = 4'd1; reg_loop = 1'b1; l0 = log_n;
         pulse(reg_sw);
         while (log_n < l0 + 5) @(negedge clk);
         chk(reg_act == 1'b1, "R9 still running after wrap", reg_act, 1);
         reg_loop = 1'b0;
         wait_idle();
         n = log_n - l0;
         ok = (n % 2 == 0) && (n >= 6);
         for (int k = 0; k < n; k++) if (ch_log[(l0+k)%256] != CH_W'(8 + (k % 2))) ok = 0;
         chk(ok == 1, "R9 wrap order and stop at list end", n, 6);
      end

      // overrun: R10
      chk(ovr == 1'b0, "R10 no overrun while acked", ovr, 0);
      auto_ack = 1'b0;
      set_reg(11, 1); reg_cnt = 4'd1;
      pulse(reg_sw);
      wait_idle();
      chk(ovr == 1'b1, "R10 overrun set", ovr, 1);
      chk(dma_req == 1'b1 && reg_res == fres(5'd12), "R3 latest result held with request",
          reg_res, fres(5'd12));
      auto_ack = 1'b1;
      repeat (4) @(negedge clk);
      chk(!dma_req && ovr, "R10 overrun sticky after ack", {dma_req, ovr}, 1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule